// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two independent predictors each form an opinion. The first is a global predictor, whose table of 2-bit saturating counters is indexed by a shift register holding the latest resolved outcomes of all branches. The second is a two-level local predictor. Low branch-address bits select a per-branch history word, and that word indexes a table of 3-bit saturating counters. A chooser table of 2-bit counters, indexed by the same global history, decides whose opinion becomes the answer.

Lookup is purely combinational. The front end presents branch-address bits on the lookup port and reads the predicted direction in the same cycle. When the branch resolves, the back end presents its address bits and actual outcome on the update port for one cycle. All tables and the global history then advance at the next clock edge. The update recomputes both opinions from the current state, so nothing from the lookup has to travel down the pipeline.

At full size the global history is 12 bits, the local history table has 1K words of 10 bits, the global and chooser tables have 4K entries each, and the local counter table has 1K entries: about 29K bits in total. The defaults are smaller so that simulation stays light. Every counter is an explicit state machine. A 2-bit counter walks the states STRONG_NT, WEAK_NT, WEAK_T and STRONG_T (encodings 0 to 3). A taken outcome moves it one step toward STRONG_T, saturating there. A not-taken outcome moves it one step toward STRONG_NT, saturating there.

Top module: `tourney_predictor`

## Requirements
- R1: While reset is held and in the first cycle after it, every counter sits in its weakly-not-taken state (2-bit value 1, 3-bit value 3), every history is zero, and `lk_taken` is 0 for every `lk_addr`.
- R2: Each cycle with `up_valid`=1, the global history shifts left by one and `up_taken` enters bit 0.
- R3: A 2-bit counter (global or chooser) saturates at 0 and 3, steps up on an increment and down otherwise, and reads as taken (or, for the chooser, "use global") when its value is 2 or 3.
- R4: The local history word is selected by `up_addr` (or `lk_addr`) taken directly as an index. On update, the selected word shifts left with `up_taken` entering bit 0, and no other word changes.
- R5: A 3-bit local counter, indexed by the local history word, saturates at 0 and 7, steps toward the outcome on every update, and predicts taken when its value is 4 or more.
- R6: `lk_taken` equals the global opinion when the chooser entry at the current global history is 2 or more, and the local opinion otherwise.
- R7: On update, the chooser entry at the current global history moves toward the global predictor if only the global opinion matched `up_taken`, and toward the local predictor if only the local opinion matched. It does not move when the two opinions agree.
- R8: `lk_taken` is combinational and reflects the state before any update applied at the same clock edge.
- R9: A cycle with `up_valid`=0 changes no state, whatever `up_addr` and `up_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_addr | input | LIDX_W | Branch address bits for a lookup |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_addr | input | LIDX_W | Address bits of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch |

## Verification
The assertions assume the update strobe is low during reset and that reset is applied only once. They also assume `lk_addr` changes only between clock edges, so that a held lookup address with no update must give a held prediction. The bench drives every input at the falling edge and keeps `up_valid` low throughout reset. Its random phase draws addresses from a small pool, so histories repeat and the chooser and counters reach their saturation states, alongside the directed training runs.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr2_e;

    // Next state of a 2-bit direction counter (R3)
    function automatic logic [1:0] ctr2_step(input ctr2_e cur, input logic inc);
        ctr2_e nxt;
        unique case (cur)
            CTR_STRONG_NT: nxt = inc ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = inc ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = inc ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = inc ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_WEAK_NT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
    parameter int IDX_W = 8,
    parameter int CW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hit,
    input  logic [IDX_W-1:0] up_idx,
    output logic             up_hit,
    input  logic             up_en,
    input  logic             up_inc
);
    localparam int          DEPTH  = 1 << IDX_W;
    localparam logic [CW-1:0] MAXV = {CW{1'b1}};
    // weakly-not-taken: one below the taken threshold
    localparam logic [CW-1:0] INITV = {1'b0, {(CW-1){1'b1}}};

    logic [CW-1:0] mem [DEPTH];
    logic [CW-1:0] cur;
    logic [CW-1:0] nxt;

    assign cur    = mem[up_idx];
    assign rd_hit = mem[rd_idx][CW-1];
    assign up_hit = cur[CW-1];

    generate
        if (CW == 2) begin : g_fsm2
            assign nxt = tp_pkg::ctr2_step(tp_pkg::ctr2_e'(cur), up_inc);
        end else begin : g_satn
            always_comb begin
                if (up_inc) nxt = (cur == MAXV)     ? cur : cur + CW'(1);
                else        nxt = (cur == '0)       ? cur : cur - CW'(1);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= INITV;
        end else if (up_en) begin
            mem[up_idx] <= nxt;
        end
    end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W = 6,
    parameter int HW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [HW-1:0]    rd_hist,
    input  logic [IDX_W-1:0] up_idx,
    output logic [HW-1:0]    up_hist,
    input  logic             up_en,
    input  logic             up_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HW-1:0] hist [DEPTH];

    assign rd_hist = hist[rd_idx];
    assign up_hist = hist[up_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
        end else if (up_en) begin
            hist[up_idx] <= {up_hist[HW-2:0], up_bit};
        end
    end
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
    parameter int GHIST_W = 8,
    parameter int LIDX_W  = 6,
    parameter int LHIST_W = 6,
    parameter int LCTR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LIDX_W-1:0] lk_addr,
    output logic              lk_taken,
    input  logic              up_valid,
    input  logic [LIDX_W-1:0] up_addr,
    input  logic              up_taken
);
    logic [GHIST_W-1:0] ghist_q;
    logic [LHIST_W-1:0] lk_lhist, up_lhist;
    logic lk_gp, lk_lp, lk_usg;
    logic up_gp, up_lp, up_usg_unused;
    logic ch_en, ch_inc;

    always_ff @(posedge clk) begin
        if (!rst_n)        ghist_q <= '0;
        else if (up_valid) ghist_q <= {ghist_q[GHIST_W-2:0], up_taken};
    end

    tp_hist_table #(.IDX_W(LIDX_W), .HW(LHIST_W)) u_lhist (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_addr), .rd_hist(lk_lhist),
        .up_idx(up_addr), .up_hist(up_lhist),
        .up_en(up_valid), .up_bit(up_taken)
    );

    tp_sat_table #(.IDX_W(LHIST_W), .CW(LCTR_W)) u_lctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_lhist), .rd_hit(lk_lp),
        .up_idx(up_lhist), .up_hit(up_lp),
        .up_en(up_valid), .up_inc(up_taken)
    );

    tp_sat_table #(.IDX_W(GHIST_W), .CW(2)) u_gctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ghist_q), .rd_hit(lk_gp),
        .up_idx(ghist_q), .up_hit(up_gp),
        .up_en(up_valid), .up_inc(up_taken)
    );

    assign ch_en  = up_valid && (up_gp != up_lp);
    assign ch_inc = (up_gp == up_taken);

    tp_sat_table #(.IDX_W(GHIST_W), .CW(2)) u_choose (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ghist_q), .rd_hit(lk_usg),
        .up_idx(ghist_q), .up_hit(up_usg_unused),
        .up_en(ch_en), .up_inc(ch_inc)
    );

    assign lk_taken = lk_usg ? lk_gp : lk_lp;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int GHIST_W = 8,
    parameter int LIDX_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LIDX_W-1:0] lk_addr,
    input logic              lk_taken,
    input logic              up_valid,
    input logic              up_taken,
    input logic [GHIST_W-1:0] ghist
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !lk_taken);

    p_hist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(up_taken)});

    p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ghist));

    p_pred_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> (!$stable(lk_addr) || $stable(lk_taken)));
endmodule

bind tourney_predictor tp_checker #(.GHIST_W(GHIST_W), .LIDX_W(LIDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_taken(up_taken), .ghist(ghist_q)
);

// File: tb/tourney_predictor_test.sv
`timescale 1ns/1ps
module tourney_predictor_test;
    localparam int GW = 8, LI = 6, LH = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [LI-1:0] lk_addr = '0, up_addr = '0;
    logic up_valid = 1'b0, up_taken = 1'b0, lk_taken;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tourney_predictor uut (.clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken));

    int m_gh;
    int m_gct [1<<GW];
    int m_ch  [1<<GW];
    int m_lht [1<<LI];
    int m_lct [1<<LH];

    function automatic int sat(int v, int mx, bit inc);
        if (inc) return (v == mx) ? v : v + 1;
        return (v == 0) ? v : v - 1;
    endfunction

    function automatic bit mpred(int a);
        bit gp, lp;
        gp = m_gct[m_gh] >= 2;
        lp = m_lct[m_lht[a]] >= 4;
        return (m_ch[m_gh] >= 2) ? gp : lp;
    endfunction

    task automatic mreset();
        m_gh = 0;
        for (int i = 0; i < (1<<GW); i++) begin m_gct[i] = 1; m_ch[i] = 1; end
        for (int i = 0; i < (1<<LI); i++) m_lht[i] = 0;
        for (int i = 0; i < (1<<LH); i++) m_lct[i] = 3;
    endtask

    task automatic mupd(int a, bit t);
        int lh;
        bit gp, lp;
        lh = m_lht[a];
        gp = m_gct[m_gh] >= 2;
        lp = m_lct[lh] >= 4;
        if (gp != lp) m_ch[m_gh] = sat(m_ch[m_gh], 3, gp == t);
        m_gct[m_gh] = sat(m_gct[m_gh], 3, t);
        m_lct[lh]   = sat(m_lct[lh], 7, t);
        m_lht[a]    = ((lh << 1) | int'(t)) & ((1<<LH)-1);
        m_gh        = ((m_gh << 1) | int'(t)) & ((1<<GW)-1);
    endtask

    task automatic check(string req, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s lk_addr=%0d actual=%0b expected=%0b", req, lk_addr, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, check lookup before the rising edge (R8)
    task automatic step(string req, int la, bit v, int ua, bit t);
        @(negedge clk);
        lk_addr = LI'(la); up_valid = v; up_addr = LI'(ua); up_taken = t;
        #1;
        check(req, lk_taken, mpred(la));
        if (v) mupd(ua, t);
    endtask

    initial begin
        mreset();
        repeat (4) @(negedge clk);
        // R1: prediction is not-taken while reset is held
        lk_addr = LI'(9); #1; check("R1", lk_taken, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); lk_addr = LI'(i * 7); #1;
            check("R1", lk_taken, 1'b0);
        end
        // R9: stray update data without the strobe changes nothing
        for (int i = 0; i < 40; i++) step("R9", i % 64, 1'b0, $urandom % 64, 1'(1));
        for (int i = 0; i < 8; i++) step("R9", i * 5, 1'b0, 0, 1'b0);
        // R5: one branch always taken; local counters climb and saturate
        for (int i = 0; i < 24; i++) step("R5", 5, 1'b1, 5, 1'b1);
        @(negedge clk); up_valid = 1'b0; lk_addr = LI'(5); #1;
        check("R5", lk_taken, 1'b1);
        // R3: one not-taken after saturation still predicts taken
        step("R3", 5, 1'b1, 5, 1'b0);
        step("R3", 5, 1'b0, 0, 1'b0);
        // R4: a different address has its own untrained history
        step("R4", 6, 1'b0, 0, 1'b0);
        for (int i = 0; i < 10; i++) step("R4", 6, 1'b1, 6, 1'b0);
        // R2: two branches alternate in outcome; global history learns the pattern
        for (int i = 0; i < 60; i++) step("R2", (i % 2) ? 2 : 1, 1'b1, (i % 2) ? 2 : 1, i % 2 == 0);
        // R8: lookup and update of the same address in one cycle
        for (int i = 0; i < 30; i++) step("R8", 11, 1'b1, 11, (i % 3) != 0);
        // R6 / R7: random mix over a small address pool, biased outcomes
        begin
            int unsigned seed_v = $urandom(32'd20240611);
            seed_v = seed_v;
        end
        for (int i = 0; i < 6000; i++) begin
            int a  = $urandom % 8;
            int la = $urandom % 8;
            bit t  = ((a & 1) == 1) ? (($urandom % 8) != 0) : (($urandom % 4) == 0);
            bit v  = ($urandom % 8) != 0;
            step((i % 2) ? "R6" : "R7", la, v, a, t);
        end
        // R3: chooser / global saturation under a long taken run
        for (int i = 0; i < 20; i++) step("R3", 3, 1'b1, 3, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule